// File: doc/BRIEF.md
# I2C Line Stuck-Low Detector

This block sits beside an I2C controller and watches its clock and data lines. Each line has its own counter. The counter advances on every core-clock cycle in which the line is sampled low while the controller is enabled. When a counter first reaches its programmed limit, the block latches a sticky fault for that line. The limit registers count core-clock cycles. Their reset value comes from a default timeout in milliseconds and the core clock frequency in MHz: cycles = ms × MHz × 1000, which is 3,300,000 for 30 ms at 110 MHz.

The two lines report along different paths. A stuck clock line sets a raw interrupt bit, and that bit passes through an interrupt mask. A stuck data line sets a cause bit in an abort-source register and also raises the raw transmit-abort interrupt bit. Software reads a clear register to drop the faults, normally once its recovery sequence has run. A single read of the combined clear register drops every fault in the same cycle.

Top module: `line_stuck_monitor`

## Requirements
- R1: After reset, both limit registers (0xAC clock line, 0xB0 data line) read 3,300,000. The mask register (0x30) reads 0x00004040. The raw status (0x34), masked status (0x2C) and abort source (0x80) read 0, and `irqOut` is 0.
- R2: With the controller enabled and the clock line limit set to L, raw status bit 14 becomes 1 at the clock edge of the L-th consecutive low sample of `sclIn`. After L-1 low samples it is still 0.
- R3: With the data line limit set to L, the L-th consecutive enabled low sample of `sdaIn` sets abort-source bit 17 and raw status bit 6 (transmit abort) together.
- R4: A single high sample of a line returns that line's count to zero, so two low runs of L-1 samples separated by one high sample raise no fault.
- R5: A line counts only while `ctrlEnable` is 1. A cycle with `ctrlEnable` at 0 returns the count to zero.
- R6: A fault latches once per low period. After it is cleared while the line is still low, it does not set again until the line has been sampled high and then low for L more samples.
- R7: A limit of 0 or of all ones disables detection on that line.
- R8: Masked status (0x2C) equals raw status ANDed with the mask. Only mask bits 14 and 6 are writable. `irqOut` is 1 exactly when any masked status bit is 1.
- R9: A read of 0x40 clears raw bits 14 and 6 and abort-source bit 17 in the same cycle.
- R10: A read of 0x54 clears raw bit 6 and abort-source bit 17 and leaves raw bit 14 unchanged.
- R11: The limit registers accept writes of all 32 bits and read them back. Writes to the status, abort-source and clear offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Controller enabled; counting allowed |
| sclIn | input | 1 | Synchronized clock line level |
| sdaIn | input | 1 | Synchronized data line level |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of a clear offset has side effects |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after `regRdEn` |
| irqOut | output | 1 | OR of the masked status bits |

## Verification
The bench sweeps limits 1 to 5 against low runs from 0 to L+1 samples on each line. A comparator that is off by one would show up as a flag appearing one sample early or one sample late. Other runs target a single high glitch and a one-cycle disable in the middle of a low run, which catch a counter that fails to restart. A test clears a fault while the line is still held low, which exposes a flag that re-triggers on every cycle. Further checks cover limits of 0 and all ones, and the asymmetric clear registers. A design that wired the two clear paths the wrong way round would leave the clock-line fault set, or would wipe it when only the abort clear was read.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  localparam logic [ADDR_W-1:0] OFS_MASKED    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_MASK      = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_RAW       = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CLR_ALL   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CLR_ABORT = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_ABORT_SRC = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_SCL_LIMIT = 8'hAC;
  localparam logic [ADDR_W-1:0] OFS_SDA_LIMIT = 8'hB0;

  localparam int BIT_TX_ABORT  = 6;
  localparam int BIT_SCL_STUCK = 14;
  localparam int BIT_SDA_CAUSE = 17;

  typedef struct packed {
    logic [NUM_LINES-1:0] wrLimit;
    logic                 wrMask;
    logic                 clrAll;
    logic                 clrAbort;
  } strobe_t;
endpackage

// File: rtl/lsm_line_counter.sv
module lsm_line_counter #(
  parameter int LIMIT_W = 32,
  parameter logic [LIMIT_W-1:0] RESET_LIMIT = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineIn,
  input  logic               enable,
  input  logic               wrLimit,
  input  logic [LIMIT_W-1:0] wrData,
  output logic [LIMIT_W-1:0] limit,
  output logic [LIMIT_W-1:0] count,
  output logic               hit
);
  logic [LIMIT_W-1:0] limitQ, cntQ;
  logic [LIMIT_W:0]   nextCnt;
  logic               atLimit, detectOff, counting;

  assign nextCnt   = {1'b0, cntQ} + 1'b1;
  assign atLimit   = (cntQ >= limitQ);
  assign detectOff = (limitQ == '0) || (limitQ == '1);
  assign counting  = enable && !lineIn;
  assign hit       = counting && !atLimit && !detectOff &&
                     (nextCnt == {1'b0, limitQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= RESET_LIMIT;
    end else if (wrLimit) begin
      limitQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (!counting) begin
      cntQ <= '0;
    end else if (!atLimit) begin
      cntQ <= nextCnt[LIMIT_W-1:0];
    end
  end

  assign limit = limitQ;
  assign count = cntQ;
endmodule

// File: rtl/lsm_datapath.sv
module lsm_datapath
  import lsm_pkg::*;
#(
  parameter int LIMIT_W = 32,
  parameter logic [LIMIT_W-1:0] RESET_LIMIT = '1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sclIn,
  input  logic                            sdaIn,
  input  logic                            enable,
  input  strobe_t                         stb,
  input  logic [DATA_W-1:0]               wrData,
  output logic [NUM_LINES-1:0][LIMIT_W-1:0] limitVec,
  output logic [NUM_LINES-1:0][LIMIT_W-1:0] cntVec,
  output logic [DATA_W-1:0]               rawStat,
  output logic [DATA_W-1:0]               maskReg,
  output logic [DATA_W-1:0]               maskedStat,
  output logic [DATA_W-1:0]               abortSrc,
  output logic                            irq
);
  logic [NUM_LINES-1:0] lineLvl, hitVec;
  logic sclStuckQ, txAbortQ, sdaCauseQ;
  logic [1:0] maskQ;

  assign lineLvl[LINE_SCL] = sclIn;
  assign lineLvl[LINE_SDA] = sdaIn;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    lsm_line_counter #(.LIMIT_W(LIMIT_W), .RESET_LIMIT(RESET_LIMIT)) u_cnt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (lineLvl[i]),
      .enable (enable),
      .wrLimit(stb.wrLimit[i]),
      .wrData (wrData[LIMIT_W-1:0]),
      .limit  (limitVec[i]),
      .count  (cntVec[i]),
      .hit    (hitVec[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclStuckQ <= 1'b0;
      txAbortQ  <= 1'b0;
      sdaCauseQ <= 1'b0;
    end else begin
      if (hitVec[LINE_SCL])        sclStuckQ <= 1'b1;
      else if (stb.clrAll)         sclStuckQ <= 1'b0;
      if (hitVec[LINE_SDA]) begin
        txAbortQ  <= 1'b1;
        sdaCauseQ <= 1'b1;
      end else if (stb.clrAll || stb.clrAbort) begin
        txAbortQ  <= 1'b0;
        sdaCauseQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskQ <= 2'b11;
    else if (stb.wrMask) maskQ <= {wrData[BIT_SCL_STUCK], wrData[BIT_TX_ABORT]};
  end

  always_comb begin
    rawStat  = '0;
    maskReg  = '0;
    abortSrc = '0;
    rawStat[BIT_SCL_STUCK]  = sclStuckQ;
    rawStat[BIT_TX_ABORT]   = txAbortQ;
    maskReg[BIT_SCL_STUCK]  = maskQ[1];
    maskReg[BIT_TX_ABORT]   = maskQ[0];
    abortSrc[BIT_SDA_CAUSE] = sdaCauseQ;
  end

  assign maskedStat = rawStat & maskReg;
  assign irq        = |maskedStat;
endmodule

// File: rtl/lsm_control.sv
module lsm_control
  import lsm_pkg::*;
#(
  parameter int LIMIT_W = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic                              regRdEn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [NUM_LINES-1:0][LIMIT_W-1:0] limitVec,
  input  logic [DATA_W-1:0]                 rawStat,
  input  logic [DATA_W-1:0]                 maskReg,
  input  logic [DATA_W-1:0]                 maskedStat,
  input  logic [DATA_W-1:0]                 abortSrc,
  output strobe_t                           stb,
  output logic [DATA_W-1:0]                 regRdData
);
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    stb = '0;
    stb.wrLimit[LINE_SCL] = regWrEn && (regAddr == OFS_SCL_LIMIT);
    stb.wrLimit[LINE_SDA] = regWrEn && (regAddr == OFS_SDA_LIMIT);
    stb.wrMask            = regWrEn && (regAddr == OFS_MASK);
    stb.clrAll            = regRdEn && (regAddr == OFS_CLR_ALL);
    stb.clrAbort          = regRdEn && (regAddr == OFS_CLR_ABORT);
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      OFS_MASKED:    rdMux = maskedStat;
      OFS_MASK:      rdMux = maskReg;
      OFS_RAW:       rdMux = rawStat;
      OFS_ABORT_SRC: rdMux = abortSrc;
      OFS_SCL_LIMIT: rdMux[LIMIT_W-1:0] = limitVec[LINE_SCL];
      OFS_SDA_LIMIT: rdMux[LIMIT_W-1:0] = limitVec[LINE_SDA];
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end
endmodule

// File: rtl/line_stuck_monitor.sv
module line_stuck_monitor
  import lsm_pkg::*;
#(
  parameter int LIMIT_W    = 32,
  parameter int CLK_MHZ    = 110,
  parameter int DEFAULT_MS = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEnable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam longint DefaultCycles = longint'(DEFAULT_MS) * longint'(CLK_MHZ) * 64'd1000;
  localparam logic [LIMIT_W-1:0] ResetLimit = LIMIT_W'(DefaultCycles);

  strobe_t stb;
  logic [NUM_LINES-1:0][LIMIT_W-1:0] limitVec, lineCnt;
  logic [DATA_W-1:0] rawStat, maskReg, maskedStat, abortSrc;

  lsm_control #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .limitVec  (limitVec),
    .rawStat   (rawStat),
    .maskReg   (maskReg),
    .maskedStat(maskedStat),
    .abortSrc  (abortSrc),
    .stb       (stb),
    .regRdData (regRdData)
  );

  lsm_datapath #(.LIMIT_W(LIMIT_W), .RESET_LIMIT(ResetLimit)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .enable    (ctrlEnable),
    .stb       (stb),
    .wrData    (regWrData),
    .limitVec  (limitVec),
    .cntVec    (lineCnt),
    .rawStat   (rawStat),
    .maskReg   (maskReg),
    .maskedStat(maskedStat),
    .abortSrc  (abortSrc),
    .irq       (irqOut)
  );
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker
  import lsm_pkg::*;
#(
  parameter int LIMIT_W = 32
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              ctrlEnable,
  input logic                              sclIn,
  input logic                              sdaIn,
  input logic                              regRdEn,
  input logic [ADDR_W-1:0]                 regAddr,
  input logic [DATA_W-1:0]                 rawStat,
  input logic [DATA_W-1:0]                 abortSrc,
  input logic [NUM_LINES-1:0][LIMIT_W-1:0] lineCnt
);
  // R4: a high sample restarts the clock-line count
  a_r4_high_restarts: assert property (@(posedge clk) disable iff (!rstN)
    sclIn |=> (lineCnt[LINE_SCL] == '0));

  // R5: disabled controller restarts both counts
  a_r5_disable_restarts: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> (lineCnt[LINE_SCL] == '0) && (lineCnt[LINE_SDA] == '0));

  // R2: the clock-line fault only rises after an enabled low sample
  a_r2_rise_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStat[BIT_SCL_STUCK]) |-> $past(!sclIn && ctrlEnable));

  // R3: the data-line cause bit never stands without the abort bit
  a_r3_cause_with_abort: assert property (@(posedge clk) disable iff (!rstN)
    abortSrc[BIT_SDA_CAUSE] |-> rawStat[BIT_TX_ABORT]);

  // R9: combined clear drops every fault when the lines are high
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == OFS_CLR_ALL && sclIn && sdaIn) |=>
      !rawStat[BIT_SCL_STUCK] && !rawStat[BIT_TX_ABORT] && !abortSrc[BIT_SDA_CAUSE]);

  // R10: abort clear keeps the clock-line fault
  a_r10_abort_clear_keeps_scl: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == OFS_CLR_ABORT && rawStat[BIT_SCL_STUCK]) |=>
      rawStat[BIT_SCL_STUCK]);
endmodule

bind line_stuck_monitor lsm_checker #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlEnable(ctrlEnable),
  .sclIn     (sclIn),
  .sdaIn     (sdaIn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .rawStat   (rawStat),
  .abortSrc  (abortSrc),
  .lineCnt   (lineCnt)
);

// File: tb/tb_line_stuck_monitor.sv
`timescale 1ns/1ps
module tb_line_stuck_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlEnable = 1'b1;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  localparam logic [7:0] A_MASKED = 8'h2C, A_MASK = 8'h30, A_RAW = 8'h34,
                         A_CLR_ALL = 8'h40, A_CLR_ABORT = 8'h54, A_SRC = 8'h80,
                         A_SCL_LIM = 8'hAC, A_SDA_LIM = 8'hB0;

  always #2.5 clk = ~clk;

  line_stuck_monitor dut (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .sclIn(sclIn), .sdaIn(sdaIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic lowScl(input int n);
    sclIn = 1'b0;
    repeat (n) @(negedge clk);
    sclIn = 1'b1;
  endtask

  task automatic lowSda(input int n);
    sdaIn = 1'b0;
    repeat (n) @(negedge clk);
    sdaIn = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    check("R1 irq", {31'b0, irqOut}, 32'h0);
    rd(A_SCL_LIM, v); check("R1 scl limit", v, 32'd3300000);
    rd(A_SDA_LIM, v); check("R1 sda limit", v, 32'd3300000);
    rd(A_MASK, v);    check("R1 mask", v, 32'h00004040);
    rd(A_RAW, v);     check("R1 raw", v, 32'h0);
    rd(A_MASKED, v);  check("R1 masked", v, 32'h0);
    rd(A_SRC, v);     check("R1 abort src", v, 32'h0);

    // R2 sweep on the clock line
    for (int lim = 1; lim <= 5; lim++) begin
      wr(A_SCL_LIM, lim);
      for (int n = 0; n <= lim + 1; n++) begin
        rd(A_CLR_ALL, v);
        lowScl(n);
        rd(A_RAW, v);
        check("R2 scl threshold", v, (n >= lim) ? 32'h00004000 : 32'h0);
      end
    end

    // R3 sweep on the data line
    for (int lim = 1; lim <= 5; lim++) begin
      wr(A_SDA_LIM, lim);
      for (int n = 0; n <= lim + 1; n++) begin
        rd(A_CLR_ALL, v);
        lowSda(n);
        rd(A_SRC, v);
        check("R3 sda cause", v, (n >= lim) ? 32'h00020000 : 32'h0);
      end
    end
    rd(A_RAW, v); check("R3 tx abort bit", v, 32'h00000040);

    // R4 glitch high restarts
    wr(A_SCL_LIM, 4);
    rd(A_CLR_ALL, v);
    lowScl(3); @(negedge clk); lowScl(3);
    rd(A_RAW, v); check("R4 high sample restart", v, 32'h0);

    // R5 enable gating
    ctrlEnable = 1'b0;
    lowScl(10);
    ctrlEnable = 1'b1;
    rd(A_RAW, v); check("R5 disabled no count", v, 32'h0);
    sclIn = 1'b0;
    repeat (3) @(negedge clk);
    ctrlEnable = 1'b0;
    @(negedge clk);
    ctrlEnable = 1'b1;
    repeat (3) @(negedge clk);
    sclIn = 1'b1;
    rd(A_RAW, v); check("R5 disable restarts", v, 32'h0);

    // R6 one shot per low period
    wr(A_SCL_LIM, 3);
    sclIn = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_RAW, v); check("R6 first set", v, 32'h00004000);
    rd(A_CLR_ALL, v);
    repeat (10) @(negedge clk);
    rd(A_RAW, v); check("R6 no retrigger", v, 32'h0);
    sclIn = 1'b1;
    @(negedge clk);
    lowScl(3);
    rd(A_RAW, v); check("R6 retrigger after high", v, 32'h00004000);
    rd(A_CLR_ALL, v);

    // R7 disabled limits
    wr(A_SCL_LIM, 32'h0);
    wr(A_SDA_LIM, 32'hFFFFFFFF);
    sclIn = 1'b0; sdaIn = 1'b0;
    repeat (20) @(negedge clk);
    sclIn = 1'b1; sdaIn = 1'b1;
    rd(A_RAW, v); check("R7 limit zero and all ones", v, 32'h0);
    rd(A_SRC, v); check("R7 no sda cause", v, 32'h0);

    // R8 masking
    wr(A_SCL_LIM, 2);
    lowScl(2);
    wr(A_MASK, 32'h0);
    check("R8 irq masked off", {31'b0, irqOut}, 32'h0);
    rd(A_MASKED, v); check("R8 masked zero", v, 32'h0);
    rd(A_RAW, v);    check("R8 raw kept", v, 32'h00004000);
    wr(A_MASK, 32'hFFFFFFFF);
    rd(A_MASK, v);   check("R8 mask writable bits", v, 32'h00004040);
    rd(A_MASKED, v); check("R8 masked shows", v, 32'h00004000);
    check("R8 irq on", {31'b0, irqOut}, 32'h1);

    // R10 abort clear keeps clock fault
    wr(A_SDA_LIM, 2);
    lowSda(2);
    rd(A_RAW, v); check("R10 both set", v, 32'h00004040);
    rd(A_CLR_ABORT, v);
    rd(A_RAW, v); check("R10 raw after abort clear", v, 32'h00004000);
    rd(A_SRC, v); check("R10 src after abort clear", v, 32'h0);

    // R9 combined clear
    lowSda(2);
    rd(A_CLR_ALL, v);
    rd(A_RAW, v); check("R9 raw cleared", v, 32'h0);
    rd(A_SRC, v); check("R9 src cleared", v, 32'h0);
    check("R9 irq low", {31'b0, irqOut}, 32'h0);

    // R11 limit width and read-only offsets
    wr(A_SCL_LIM, 32'h12345678);
    rd(A_SCL_LIM, v); check("R11 scl limit readback", v, 32'h12345678);
    wr(A_SDA_LIM, 32'hA5A5_0003);
    rd(A_SDA_LIM, v); check("R11 sda limit readback", v, 32'hA5A50003);
    wr(A_RAW, 32'hFFFFFFFF);
    wr(A_SRC, 32'hFFFFFFFF);
    wr(A_MASKED, 32'hFFFFFFFF);
    wr(A_CLR_ALL, 32'hFFFFFFFF);
    rd(A_RAW, v); check("R11 raw not writable", v, 32'h0);
    rd(A_SRC, v); check("R11 src not writable", v, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule